// File: doc/BRIEF.md
# Address-Window Data Trace Filter

This block sits beside the load/store bus of one processing core and decides which bus accesses turn into trace records. Two address windows can be programmed independently. Each window has an inclusive lower and upper bound and its own read-qualify and write-qualify bits. A qualifying access becomes a record that carries the message type, the window index, the address, the data and a free-running timestamp. Records queue in a small FIFO, and the trace port drains that FIFO through a valid/ready pair.

Instruction-fetch tracing has its own start/stop state. A fetch at the start watchpoint address turns it on, and a fetch at the stop watchpoint address turns it off. A global trace enable suppresses every record this block would produce. Demand can exceed what the port drains. When that happens, records are dropped, a saturating loss counter counts them, and the next record that is accepted carries an overrun flag.

Top module: `dtrace_filter`

## Requirements
- R1: An access hits window i only when acc_valid_i is high and win_lo_i[i] <= acc_addr_i <= win_hi_i[i], with both bounds inclusive.
- R2: A read (acc_we_i=0) can hit window i only when win_rd_en_i[i] is 1. A write (acc_we_i=1) can hit window i only when win_wr_en_i[i] is 1. A record holds the access's address in rec_addr_o and its data in rec_data_o.
- R3: rec_type_o encodes the record kind as 0 for a data read, 1 for a data write and 2 for a fetch. It never shows 3 while rec_valid_o is high.
- R4: When both windows hit one access, exactly one record is produced, with rec_win_o = 0. When only window 1 hits, rec_win_o = 1.
- R5: fetch_active_o is 0 after reset. After a cycle with fetch_valid_i high, it becomes 0 if fetch_addr_i equals wp_stop_addr_i. Otherwise it becomes 1 if fetch_addr_i equals wp_start_addr_i. In every other case it holds. A stop match wins over a start match.
- R6: A fetch produces a record (type 2, rec_win_o = 0, rec_data_o = 0, rec_addr_o = fetch address) when fetch_valid_i is high and fetch_active_o is already 1 in that cycle.
- R7: While trace_en_i is 0, no record enters the FIFO. Watchpoint state still follows fetches.
- R8: Records leave the FIFO in arrival order. A record shows at the outputs in the cycle after its access. The FIFO holds 8 records, and the head record stays unchanged while rec_ready_i is low.
- R9: If a record arrives while the FIFO holds 8 entries, the record is dropped even if a pop happens in the same cycle. Each dropped record adds 1 to loss_cnt_o, which saturates at 255.
- R10: rec_ovf_o is 1 on the first record accepted after any drop, and 0 on every other record.
- R11: When a data record and a fetch record arise in the same cycle, the data record is offered to the FIFO and the fetch record is dropped and counted as a loss.
- R12: rec_ts_o is the value of a 16-bit counter that is 0 in the first cycle after reset, advances by one each cycle and wraps. The value is sampled in the cycle of the access.
- R13: During reset, rec_valid_o = 0, loss_cnt_o = 0 and fetch_active_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trace_en_i | input | 1 | Global enable for record generation |
| win_lo_i | input | 2x32 | Inclusive lower bound per window |
| win_hi_i | input | 2x32 | Inclusive upper bound per window |
| win_rd_en_i | input | 2 | Per-window read qualify |
| win_wr_en_i | input | 2 | Per-window write qualify |
| acc_valid_i | input | 1 | Load/store access present |
| acc_we_i | input | 1 | Access is a write |
| acc_addr_i | input | 32 | Access address |
| acc_data_i | input | 32 | Access data |
| fetch_valid_i | input | 1 | Instruction fetch present |
| fetch_addr_i | input | 32 | Fetch address |
| wp_start_addr_i | input | 32 | Start watchpoint address |
| wp_stop_addr_i | input | 32 | Stop watchpoint address |
| fetch_active_o | output | 1 | Fetch trace active state |
| rec_valid_o | output | 1 | FIFO head record valid |
| rec_ready_i | input | 1 | Trace port takes the head record |
| rec_type_o | output | 2 | Record type code |
| rec_win_o | output | 1 | Window index of the hit |
| rec_addr_o | output | 32 | Record address |
| rec_data_o | output | 32 | Record data |
| rec_ts_o | output | 16 | Record timestamp |
| rec_ovf_o | output | 1 | A record was lost just before this one |
| loss_cnt_o | output | 8 | Saturating count of dropped records |

## Verification
Directed reads and writes at each window bound and one step outside it show whether the comparisons are inclusive. An access in the overlap of the two windows separates lowest-index priority from a duplicated record. Toggling the qualify bits shows that read and write filtering are independent.

A fetch walk through start, traced, stop and both-watchpoints-equal checks the state machine's precedence and the rule that the start fetch itself is not traced. A long stall with the port not ready fills the FIFO and pushes the loss counter into saturation, and the flagged record after it shows the overrun flag. A constrained-random phase then mixes these cases over a small address space with a draining port that stalls at random.

// File: rtl/dtrace_pkg.sv
package dtrace_pkg;
  localparam int unsigned NWIN = 2;
  localparam int unsigned WIW  = 1;

  typedef enum logic [1:0] {
    MSG_RD    = 2'd0,
    MSG_WR    = 2'd1,
    MSG_FETCH = 2'd2
  } msg_e;
endpackage

// File: rtl/dtrace_win_match.sv
module dtrace_win_match #(
  parameter int unsigned AW = 32
) (
  input  logic          valid_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  output logic          hit_o
);
  logic in_range;
  logic attr_ok;

  assign in_range = (addr_i >= lo_i) && (addr_i <= hi_i);
  assign attr_ok  = we_i ? wr_en_i : rd_en_i;
  assign hit_o    = valid_i && attr_ok && in_range;
endmodule

// File: rtl/dtrace_fetch_ctl.sv
module dtrace_fetch_ctl #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic [AW-1:0] wp_start_i,
  input  logic [AW-1:0] wp_stop_i,
  output logic          active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
    end else if (fetch_valid_i) begin
      // stop has precedence
      if (fetch_addr_i == wp_stop_i)       active_o <= 1'b0;
      else if (fetch_addr_i == wp_start_i) active_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dtrace_fifo.sv
module dtrace_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  output logic         full_o,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] dout_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0] CNT_FULL = PW'(DEPTH) | ((PW+1)'(DEPTH) & {1'b1, {PW{1'b0}}});
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [PW:0]   cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == CNT_FULL);
  assign valid_o = (cnt != '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && valid_o;
  assign dout_o  = mem[rptr];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/dtrace_filter.sv
module dtrace_filter
  import dtrace_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned TW    = 16,
  parameter int unsigned LW    = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      trace_en_i,
  input  logic [NWIN-1:0][AW-1:0]   win_lo_i,
  input  logic [NWIN-1:0][AW-1:0]   win_hi_i,
  input  logic [NWIN-1:0]           win_rd_en_i,
  input  logic [NWIN-1:0]           win_wr_en_i,
  input  logic                      acc_valid_i,
  input  logic                      acc_we_i,
  input  logic [AW-1:0]             acc_addr_i,
  input  logic [DW-1:0]             acc_data_i,
  input  logic                      fetch_valid_i,
  input  logic [AW-1:0]             fetch_addr_i,
  input  logic [AW-1:0]             wp_start_addr_i,
  input  logic [AW-1:0]             wp_stop_addr_i,
  output logic                      fetch_active_o,
  output logic                      rec_valid_o,
  input  logic                      rec_ready_i,
  output logic [1:0]                rec_type_o,
  output logic [WIW-1:0]            rec_win_o,
  output logic [AW-1:0]             rec_addr_o,
  output logic [DW-1:0]             rec_data_o,
  output logic [TW-1:0]             rec_ts_o,
  output logic                      rec_ovf_o,
  output logic [LW-1:0]             loss_cnt_o
);
  typedef struct packed {
    logic [1:0]     typ;
    logic [WIW-1:0] win;
    logic [AW-1:0]  addr;
    logic [DW-1:0]  data;
    logic [TW-1:0]  ts;
    logic           ovf;
  } rec_t;

  localparam int unsigned RW = $bits(rec_t);
  localparam logic [LW+1:0] LOSS_MAX = {2'b00, {LW{1'b1}}};

  logic [NWIN-1:0] hit;
  logic [WIW-1:0]  win_sel;
  logic            dmsg, fmsg, msg_any, fifo_full, push;
  logic [1:0]      drops;
  logic [TW-1:0]   ts_q;
  logic            ovf_q;
  logic [LW+1:0]   loss_sum;
  rec_t            rec_in, rec_out;
  msg_e            dtype;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    dtrace_win_match #(.AW(AW)) u_match (
      .valid_i (acc_valid_i),
      .we_i    (acc_we_i),
      .addr_i  (acc_addr_i),
      .lo_i    (win_lo_i[i]),
      .hi_i    (win_hi_i[i]),
      .rd_en_i (win_rd_en_i[i]),
      .wr_en_i (win_wr_en_i[i]),
      .hit_o   (hit[i])
    );
  end

  // lowest hitting index wins
  always_comb begin
    win_sel = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit[i]) win_sel = WIW'(i);
    end
  end

  dtrace_fetch_ctl #(.AW(AW)) u_fetch (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fetch_valid_i (fetch_valid_i),
    .fetch_addr_i  (fetch_addr_i),
    .wp_start_i    (wp_start_addr_i),
    .wp_stop_i     (wp_stop_addr_i),
    .active_o      (fetch_active_o)
  );

  assign dmsg    = trace_en_i && (|hit);
  assign fmsg    = trace_en_i && fetch_valid_i && fetch_active_o;
  assign msg_any = dmsg || fmsg;
  assign push    = msg_any && !fifo_full;
  assign dtype   = acc_we_i ? MSG_WR : MSG_RD;
  // fetch loses to a same-cycle data record; a full FIFO drops the offered one
  assign drops   = {1'b0, dmsg && fmsg} + {1'b0, msg_any && fifo_full};

  always_comb begin
    if (dmsg) begin
      rec_in = '{typ: dtype, win: win_sel, addr: acc_addr_i, data: acc_data_i,
                 ts: ts_q, ovf: ovf_q};
    end else begin
      rec_in = '{typ: MSG_FETCH, win: '0, addr: fetch_addr_i, data: '0,
                 ts: ts_q, ovf: ovf_q};
    end
  end

  assign loss_sum = {2'b00, loss_cnt_o} + {{LW{1'b0}}, drops};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q       <= '0;
      ovf_q      <= 1'b0;
      loss_cnt_o <= '0;
    end else begin
      ts_q       <= ts_q + 1'b1;
      ovf_q      <= (drops != 2'd0) || (ovf_q && !push);
      loss_cnt_o <= (loss_sum > LOSS_MAX) ? {LW{1'b1}} : loss_sum[LW-1:0];
    end
  end

  dtrace_fifo #(.W(RW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .din_i   (rec_in),
    .full_o  (fifo_full),
    .pop_i   (rec_ready_i),
    .valid_o (rec_valid_o),
    .dout_o  (rec_out)
  );

  assign rec_type_o = rec_out.typ;
  assign rec_win_o  = rec_out.win;
  assign rec_addr_o = rec_out.addr;
  assign rec_data_o = rec_out.data;
  assign rec_ts_o   = rec_out.ts;
  assign rec_ovf_o  = rec_out.ovf;
endmodule

// File: rtl/dtrace_filter_chk.sv
module dtrace_filter_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned TW = 16,
  parameter int unsigned LW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          trace_en_i,
  input logic          fetch_valid_i,
  input logic [AW-1:0] fetch_addr_i,
  input logic [AW-1:0] wp_start_addr_i,
  input logic [AW-1:0] wp_stop_addr_i,
  input logic          fetch_active_o,
  input logic          rec_valid_o,
  input logic          rec_ready_i,
  input logic [1:0]    rec_type_o,
  input logic [AW-1:0] rec_addr_o,
  input logic [TW-1:0] rec_ts_o,
  input logic [LW-1:0] loss_cnt_o
);
  assert_stop_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i && (fetch_addr_i == wp_stop_addr_i) |=> !fetch_active_o);

  assert_start_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_i && (fetch_addr_i == wp_start_addr_i) && (fetch_addr_i != wp_stop_addr_i)
    |=> fetch_active_o);

  assert_active_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> $stable(fetch_active_o));

  assert_type_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (rec_type_o != 2'd3));

  assert_no_record_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trace_en_i && !rec_valid_o |=> !rec_valid_o);

  assert_head_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_addr_o) &&
    $stable(rec_type_o) && $stable(rec_ts_o));

  assert_loss_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, loss_cnt_o} >= {1'b0, $past(loss_cnt_o)}) &&
    ({1'b0, loss_cnt_o} - {1'b0, $past(loss_cnt_o)} <= (LW+1)'(2)));
endmodule

bind dtrace_filter dtrace_filter_chk #(.AW(AW), .TW(TW), .LW(LW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .trace_en_i      (trace_en_i),
  .fetch_valid_i   (fetch_valid_i),
  .fetch_addr_i    (fetch_addr_i),
  .wp_start_addr_i (wp_start_addr_i),
  .wp_stop_addr_i  (wp_stop_addr_i),
  .fetch_active_o  (fetch_active_o),
  .rec_valid_o     (rec_valid_o),
  .rec_ready_i     (rec_ready_i),
  .rec_type_o      (rec_type_o),
  .rec_addr_o      (rec_addr_o),
  .rec_ts_o        (rec_ts_o),
  .loss_cnt_o      (loss_cnt_o)
);

// File: tb/dtrace_filter_bench.sv
module dtrace_filter_bench;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;

  logic             trace_en_i = 0;
  logic [1:0][31:0] win_lo_i = '0, win_hi_i = '0;
  logic [1:0]       win_rd_en_i = '0, win_wr_en_i = '0;
  logic             acc_valid_i = 0, acc_we_i = 0;
  logic [31:0]      acc_addr_i = '0, acc_data_i = '0;
  logic             fetch_valid_i = 0;
  logic [31:0]      fetch_addr_i = '0, wp_start_addr_i = '0, wp_stop_addr_i = '0;
  logic             rec_ready_i = 0;
  logic             fetch_active_o, rec_valid_o, rec_win_o, rec_ovf_o;
  logic [1:0]       rec_type_o;
  logic [31:0]      rec_addr_o, rec_data_o;
  logic [15:0]      rec_ts_o;
  logic [7:0]       loss_cnt_o;

  dtrace_filter u_dtrace_filter (.*);

  // next-cycle configuration, applied inside drive()
  logic             c_en = 1;
  logic [1:0][31:0] c_lo = '0, c_hi = '0;
  logic [1:0]       c_rd = '0, c_wr = '0;
  logic [31:0]      c_wp0 = '0, c_wp1 = '0;

  typedef struct {
    logic [1:0] typ; logic win; logic [31:0] addr; logic [31:0] data;
    logic [15:0] ts; logic ovf;
  } rec_t;

  rec_t        q[$];
  logic        m_pend = 0, m_act = 0;
  int unsigned m_loss = 0;
  logic [15:0] m_ts = 0;
  int          errors = 0, checks = 0;
  string       tag = "R13";

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic hit(int i, logic we, logic [31:0] a);
    return (we ? c_wr[i] : c_rd[i]) && a >= c_lo[i] && a <= c_hi[i];
  endfunction

  task automatic compare();
    chk({tag, " R8 valid"}, rec_valid_o, q.size() != 0);
    if (q.size() != 0) begin
      chk({tag, " R3 type"}, rec_type_o, q[0].typ);
      chk({tag, " R4 win"}, rec_win_o, q[0].win);
      chk({tag, " R1 addr"}, rec_addr_o, q[0].addr);
      chk({tag, " R2 data"}, rec_data_o, q[0].data);
      chk({tag, " R12 ts"}, rec_ts_o, q[0].ts);
      chk({tag, " R10 ovf"}, rec_ovf_o, q[0].ovf);
    end
    chk({tag, " R9 loss"}, loss_cnt_o, m_loss);
    chk({tag, " R5 active"}, fetch_active_o, m_act);
  endtask

  task automatic model_step();
    logic h0, h1, dm, fm, full, pushed;
    int   drops;
    rec_t r;
    h0 = acc_valid_i && hit(0, acc_we_i, acc_addr_i);
    h1 = acc_valid_i && hit(1, acc_we_i, acc_addr_i);
    dm = c_en && (h0 || h1);
    fm = c_en && fetch_valid_i && m_act;
    full = (q.size() == 8);
    drops = 0; pushed = 0;
    if (dm && fm) drops++;
    if (dm) r = '{acc_we_i ? 2'd1 : 2'd0, !h0, acc_addr_i, acc_data_i, m_ts, m_pend};
    else    r = '{2'd2, 1'b0, fetch_addr_i, 32'd0, m_ts, m_pend};
    if (rec_ready_i && q.size() != 0) void'(q.pop_front());
    if (dm || fm) begin
      if (full) drops++;
      else begin q.push_back(r); pushed = 1; end
    end
    m_loss = (m_loss + drops > 255) ? 255 : m_loss + drops;
    m_pend = (drops != 0) || (m_pend && !pushed);
    if (fetch_valid_i) begin
      if (fetch_addr_i == c_wp1) m_act = 0;
      else if (fetch_addr_i == c_wp0) m_act = 1;
    end
    m_ts++;
  endtask

  task automatic drive(logic av, logic we, logic [31:0] a, logic [31:0] d,
                       logic fv, logic [31:0] fa, logic rdy);
    @(negedge clk_i);
    compare();
    trace_en_i = c_en; win_lo_i = c_lo; win_hi_i = c_hi;
    win_rd_en_i = c_rd; win_wr_en_i = c_wr;
    wp_start_addr_i = c_wp0; wp_stop_addr_i = c_wp1;
    acc_valid_i = av; acc_we_i = we; acc_addr_i = a; acc_data_i = d;
    fetch_valid_i = fv; fetch_addr_i = fa; rec_ready_i = rdy;
    model_step();
  endtask

  task automatic rd(logic [31:0] a); drive(1, 0, a, a ^ 32'h5A5A0000, 0, 0, 1); endtask
  task automatic wr(logic [31:0] a); drive(1, 1, a, a ^ 32'hC3C30000, 0, 0, 1); endtask
  task automatic fe(logic [31:0] a); drive(0, 0, 0, 0, 1, a, 1); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 1); endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk("R13 reset valid", rec_valid_o, 0);
    chk("R13 reset loss", loss_cnt_o, 0);
    chk("R13 reset active", fetch_active_o, 0);
    rst_ni = 1;
    rec_ready_i = 1;
    model_step();

    c_lo[0] = 16; c_hi[0] = 31; c_rd[0] = 1; c_wr[0] = 1;
    c_lo[1] = 24; c_hi[1] = 40; c_rd[1] = 1; c_wr[1] = 0;
    c_wp0 = 100; c_wp1 = 200;
    tag = "R1 bounds";
    rd(15); rd(16); rd(31); rd(32); rd(40); rd(41); wr(20); wr(35); idle(2);
    tag = "R4 overlap";
    rd(25); rd(24); wr(30); idle(2);
    tag = "R2 attrs";
    c_rd[0] = 0; rd(20); wr(20); rd(28); c_rd[0] = 1; idle(2);
    tag = "R6 fetch";
    fe(50); fe(100); fe(60); fe(61); fe(200); fe(60); idle(2);
    tag = "R5 watchpoints";
    c_wp0 = 300; c_wp1 = 300; fe(300); fe(60);
    c_wp0 = 100; c_wp1 = 200; fe(100); c_wp1 = 100; fe(100); fe(60);
    c_wp1 = 200; idle(2);
    tag = "R11 conflict";
    fe(100); drive(1, 0, 20, 32'h77, 1, 64, 1); fe(65); idle(2);
    tag = "R7 enable";
    c_en = 0; rd(20); fe(70); fe(200); fe(71); fe(100); c_en = 1; fe(72); idle(2);
    tag = "R9 overflow";
    for (int i = 0; i < 270; i++) drive(1, 1, 17 + (i % 4), i, 0, 0, 0);
    idle(10);
    tag = "R10 overrun";
    for (int i = 0; i < 12; i++) drive(1, 0, 20, i, 0, 0, i % 3 == 0);
    idle(12);

    tag = "R12 random";
    for (int n = 0; n < 3000; n++) begin
      if (n % 200 == 0) begin
        for (int w = 0; w < 2; w++) begin
          c_lo[w] = $urandom_range(0, 40);
          c_hi[w] = c_lo[w] + $urandom_range(0, 24);
          c_rd[w] = $urandom_range(0, 3) != 0;
          c_wr[w] = $urandom_range(0, 3) != 0;
        end
        c_wp0 = $urandom_range(0, 15); c_wp1 = $urandom_range(0, 15);
        c_en = $urandom_range(0, 7) != 0;
      end
      drive($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 63),
            $urandom, $urandom_range(0, 2) == 0, $urandom_range(0, 15),
            $urandom_range(0, 9) < 7);
    end
    idle(12);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule